// File: doc/BRIEF.md
# Region Write-Protected RAM

This block is a byte-wide on-chip RAM on a simple 8-bit processor bus. The bus carries an address, a write enable, write data, a read enable and read data. The RAM is split into equal power-of-two regions. Each region has one bit in a write-mask register. A write to a region whose bit is set is dropped silently. The stored byte stays as it was, and no fault is reported.

The mask register sits in a second address window, above the RAM array. Software can write it only while the processor's interrupt-mode flag is high, so code running in interrupt or privileged context can fence memory off from ordinary tasks. The mask can be read back at any time.

A build parameter removes the whole protection scheme. With protection off, every write reaches the RAM and the mask window reads as zero. Two example configurations:
- 1 KB: sixteen regions of 64 bytes, selected by address bits [9:6].
- 4 KB: thirty-two regions of 128 bytes, selected by address bits [11:7].

Top module: `wp_ram`

## Requirements
- R1: After reset the mask is all zeros, every region is writable, and `busRdData` is 0.
- R2: A read enable returns data on `busRdData` one clock later. Reads of the RAM are never blocked by the mask.
- R3: A RAM write to a region whose mask bit is 0 stores the byte.
- R4: With protection enabled, a RAM write to a region whose mask bit is 1 leaves the stored byte unchanged.
- R5: The region number is address bits [ADDR_W-1:REGION_W]. In the default 1 KB, 64-byte-region build, bits [9:6] select one of 16 regions.
- R6: Address bit ADDR_W = 1 selects the mask window, and bit ADDR_W = 0 selects the RAM. Mask byte k is chosen by the low address bits. Bit j of byte k covers region 8k+j, with bit value 1 meaning the region is protected. The mask is readable at any time.
- R7: A mask write takes effect only if `intFlag` is high in the same cycle as the write strobe. Otherwise the mask is unchanged.
- R8: A mask change governs RAM writes from the very next cycle.
- R9: A read and a write to the same RAM address in one cycle return the byte as it was before the write.
- R10: With `PROTECT_EN` = 0 (the default), every RAM write is stored, and the mask window reads 0 and ignores writes.
- R11: While no read is enabled, `busRdData` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W+1 | Byte address; the top bit selects the mask window |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| intFlag | input | 1 | Processor interrupt-mode flag |

## Verification
Two pairs of functions can meet in time. The first pair is a read and a write to the same RAM byte in the same cycle; the bench drives both strobes together and expects the returned byte to be the old content, with the new byte visible on a later read. The second pair is a mask update and a RAM write on back-to-back cycles; the bench issues a mask write and follows it immediately with a write into the affected region. The result of that write must follow the new mask. A protected and an unprotected build share one stimulus stream, so every RAM byte is judged against both an arithmetic fill pattern and the mask value the bench holds.

// File: rtl/wp_ram_pkg.sv
package wp_ram_pkg;
  typedef struct packed {
    logic ramWr;
    logic ramRd;
    logic maskRd;
  } wpStrobe_t;
endpackage

// File: rtl/wp_ram_ctrl.sv
module wp_ram_ctrl
  import wp_ram_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int REGION_W   = 6,
  parameter bit PROTECT_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              busRdEn,
  input  logic              intFlag,
  output wpStrobe_t         strobe,
  output logic [7:0]        maskByte
);
  localparam int NUM_REGIONS = 1 << (ADDR_W - REGION_W);
  localparam int MASK_BYTES  = (NUM_REGIONS + 7) / 8;
  localparam int MIDX_W      = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1;
  localparam int REG_IDX_W   = ADDR_W - REGION_W;

  logic                   maskSel;
  logic                   ramSel;
  logic [REG_IDX_W-1:0]   regionIdx;
  logic [MIDX_W-1:0]      maskIdx;
  logic [MASK_BYTES*8-1:0] maskReg;
  logic                   regionLocked;

  assign maskSel   = busAddr[ADDR_W];
  assign ramSel    = ~busAddr[ADDR_W];
  assign regionIdx = busAddr[ADDR_W-1:REGION_W];
  assign maskIdx   = busAddr[MIDX_W-1:0];

  generate
    if (PROTECT_EN) begin : g_protect
      logic maskWrOk;
      assign maskWrOk = busWrEn & maskSel & intFlag;

      for (genvar k = 0; k < MASK_BYTES; k++) begin : g_maskByte
        always_ff @(posedge clk) begin
          if (rst) begin
            maskReg[k*8 +: 8] <= 8'h00;
          end else if (maskWrOk && (int'(maskIdx) == k)) begin
            maskReg[k*8 +: 8] <= busWrData;
          end
        end
      end

      assign regionLocked = maskReg[regionIdx];

      assert_mask_reset_R1: assert property (@(posedge clk)
        rst |=> (maskReg == '0));
      assert_mask_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (busWrEn && maskSel && !intFlag) |=> $stable(maskReg));
      assert_mask_window_R6: assert property (@(posedge clk) disable iff (rst)
        !(busWrEn && maskSel) |=> $stable(maskReg));
      assert_locked_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (busWrEn && ramSel && maskReg[regionIdx]) |-> !strobe.ramWr);
    end else begin : g_plain
      logic unusedCtrl;
      assign unusedCtrl   = ^{intFlag, regionIdx};
      assign maskReg      = '0;
      assign regionLocked = 1'b0;

      assert_plain_write_R10: assert property (@(posedge clk) disable iff (rst)
        (busWrEn && ramSel) |-> strobe.ramWr);
    end
  endgenerate

  always_comb begin
    strobe.ramWr  = busWrEn & ramSel & ~regionLocked;
    strobe.ramRd  = busRdEn & ramSel;
    strobe.maskRd = busRdEn & maskSel;
  end

  always_comb begin
    maskByte = 8'h00;
    for (int k = 0; k < MASK_BYTES; k++) begin
      if (int'(maskIdx) == k) maskByte = maskReg[k*8 +: 8];
    end
  end
endmodule

// File: rtl/wp_ram_datapath.sv
module wp_ram_datapath
  import wp_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  wpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        maskByte,
  output logic [7:0]        rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] memArray [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.ramWr) memArray[ramAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= 8'h00;
    end else if (strobe.ramRd) begin
      rdData <= memArray[ramAddr];
    end else if (strobe.maskRd) begin
      rdData <= maskByte;
    end
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(strobe.ramRd || strobe.maskRd) |=> $stable(rdData));
  assert_rd_source_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.ramRd, strobe.maskRd}));
endmodule

// File: rtl/wp_ram.sv
module wp_ram
  import wp_ram_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int REGION_W   = 6,
  parameter bit PROTECT_EN = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W:0] busAddr,
  input  logic            busWrEn,
  input  logic [7:0]      busWrData,
  input  logic            busRdEn,
  output logic [7:0]      busRdData,
  input  logic            intFlag
);
  wpStrobe_t  strobe;
  logic [7:0] maskByte;

  wp_ram_ctrl #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .PROTECT_EN(PROTECT_EN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .intFlag(intFlag),
    .strobe(strobe), .maskByte(maskByte)
  );

  wp_ram_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .ramAddr(busAddr[ADDR_W-1:0]),
    .wrData(busWrData), .maskByte(maskByte), .rdData(busRdData)
  );
endmodule

// File: tb/sim_wp_ram.sv
module sim_wp_ram;
  localparam int AW = 10;
  localparam int RW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, intFlag = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] rd0, rd1;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [15:0] maskModel = 16'h0000;

  always #4 clk = ~clk;

  wp_ram #(.ADDR_W(AW), .REGION_W(RW), .PROTECT_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rd0), .intFlag(intFlag));
  wp_ram #(.ADDR_W(AW), .REGION_W(RW), .PROTECT_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rd1), .intFlag(intFlag));

  function automatic logic [7:0] patF(int a);
    return 8'((a * 7) + (a >> 8));
  endfunction
  function automatic logic [7:0] patG(int a);
    return ~patF(a) ^ 8'h3C;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(int addr, logic [7:0] data, logic iflag);
    @(negedge clk);
    busAddr = (AW+1)'(addr); busWrData = data; intFlag = iflag; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; intFlag = 1'b0;
  endtask

  task automatic busRd(int addr, logic [7:0] e0, logic [7:0] e1, string tag);
    @(negedge clk);
    busAddr = (AW+1)'(addr); busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    check({tag, " prot"}, rd0, e0);
    check({tag, " plain"}, rd1, e1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check("R1 rdData prot", rd0, 8'h00);
    check("R1 rdData plain", rd1, 8'h00);
    busRd(DEPTH + 0, 8'h00, 8'h00, "R1 R6 mask byte0");
    busRd(DEPTH + 1, 8'h00, 8'h00, "R1 R6 mask byte1");

    // R3 R2: fill every byte with mask clear, read back
    for (int a = 0; a < DEPTH; a++) busWr(a, patF(a), 1'b0);
    for (int a = 0; a < DEPTH; a++) busRd(a, patF(a), patF(a), "R3 R2 fill");

    // R7: mask write with flag low is ignored
    busWr(DEPTH + 0, 8'hFF, 1'b0);
    busRd(DEPTH + 0, 8'h00, 8'h00, "R7 flag low");

    // R6 R7 R10: mask writes with flag high
    busWr(DEPTH + 0, 8'hC3, 1'b1);
    busWr(DEPTH + 1, 8'hA5, 1'b1);
    maskModel = 16'hA5C3;
    busRd(DEPTH + 0, 8'hC3, 8'h00, "R6 R10 mask byte0");
    busRd(DEPTH + 1, 8'hA5, 8'h00, "R6 R10 mask byte1");
    busWr(DEPTH + 1, 8'h00, 1'b0);
    busRd(DEPTH + 1, 8'hA5, 8'h00, "R7 byte1 flag low");

    // R4 R5 R10: overwrite all with mask set; flag varies, must not matter
    for (int a = 0; a < DEPTH; a++) busWr(a, patG(a), a[0]);
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] e0;
      e0 = maskModel[a >> RW] ? patF(a) : patG(a);
      busRd(a, e0, patG(a), "R4 R5 R10 sweep");
    end

    // R8: clear byte0 then write region 0 in the next cycle
    @(negedge clk);
    busAddr = (AW+1)'(DEPTH); busWrData = 8'h00; intFlag = 1'b1; busWrEn = 1'b1;
    @(negedge clk);
    busAddr = '0; busWrData = 8'h5A; intFlag = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
    busRd(0, 8'h5A, 8'h5A, "R8 unlock then write");
    // R8: lock byte0 then write region 2 in the next cycle
    @(negedge clk);
    busAddr = (AW+1)'(DEPTH); busWrData = 8'hFF; intFlag = 1'b1; busWrEn = 1'b1;
    @(negedge clk);
    busAddr = (AW+1)'(8'h80); busWrData = 8'h11; intFlag = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
    busRd(8'h80, patG(8'h80), 8'h11, "R8 lock then write");

    // R9: read and write same address in one cycle (region 12 unlocked)
    @(negedge clk);
    busAddr = (AW+1)'(12'h300); busWrData = 8'h77; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R9 old data prot", rd0, patG(12'h300));
    check("R9 old data plain", rd1, patG(12'h300));
    busRd(12'h300, 8'h77, 8'h77, "R9 new data");

    // R11: output holds with no read, even across writes
    busWr(12'h301, 8'hEE, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 hold prot", rd0, 8'h77);
    check("R11 hold plain", rd1, 8'h77);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule